// File: doc/BRIEF.md
# SPI Flash Command Controller

This block is a memory-mapped SPI master that sends one serial-flash command at a time. Software uses a byte-wide register port. It loads a command byte, a transmit length and a receive length, fills a shared byte buffer, and sets a start bit. The controller then lowers chip select, clocks out the command byte and the transmit bytes, and clocks in the receive bytes. Received bytes are written into the same buffer, directly after the bytes that were sent.

Software reaches the buffer through one data register. That register has a single pointer that advances by one on every access. Once a command has finished, software clears the pointer and reads the buffer back: first the bytes it sent, then the bytes that came back. The serial side runs in SPI mode 0, most significant bit first. The serial clock comes from a fixed divider of the system clock.

The register port has no back-pressure. Every request is taken in the cycle it is presented. Read data is combinational from the address, and the side effect of a read takes place at the next clock edge. There is no streaming interface: data flows only through the register-mapped buffer.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: The byte written at address 0x00 is always the first byte on the serial output, most significant bit first. It is never taken from the buffer. Transmit byte k (k from 1) is taken from buffer entry k-1.
- R2: Address 0x1E holds an extension index and address 0x1F accesses the register that index selects. Index 5 is the transmit length and index 6 is the receive length. A transmit length written above MAX_TX (64) is stored as MAX_TX. Any other index reads 0.
- R3: A read or write at address 0x0C accesses the buffer entry at the pointer, and the pointer then moves on by one. Bits [2:0] of address 0x0D show the low three pointer bits. Writing 1 to bit 4 of address 0x02 sets the pointer to 0.
- R4: Writing 1 to bit 0 of address 0x02 starts a command. From that point, bit 0 of address 0x02 and bit 7 of address 0x03 read 1 until the command ends.
- R5: In SPI mode 0 the serial clock idles low and each of its half periods lasts DIV system clocks. The controller samples the input data on the rising edge. The first rising edge comes 3*DIV clocks after chip select falls. Chip select rises 2*DIV clocks after the last falling edge.
- R6: The receive bytes are stored at buffer entries tx..tx+rx-1. After a pointer clear, the data port returns the transmit bytes and then the received bytes, in order.
- R7: The number of bytes received is min(receive length, DEPTH - transmit length), with DEPTH = 72. The controller never writes past the end of the buffer.
- R8: While a command runs, writes to 0x00, 0x0C and 0x1F are ignored, and an ignored write to 0x0C does not move the pointer. A pointer clear requested during a command takes effect when the command ends.
- R9: With a receive length of 0, the command ends after the last transmit bit. In every case the busy bits clear on the same clock edge that chip select rises. The serial clock count is 8*(1+tx+rx).

Ports table, one row per port of the top module:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, accepted every cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Commands are tried with three kinds of input pattern, each of which separates a different class of fault.
- An opcode-only read (no transmit bytes) shows whether the opcode is taken from its own register and not from the buffer.
- A write-only command shows whether the end of transfer is timed correctly when nothing is received.
- A full 64-byte transmit with an over-long receive length shows whether the receive clamp works and whether the last buffer entry is written.

Random lengths and data between these corners check that the received bytes line up after the echoed transmit bytes. Writes made while a command is in flight check that the protected registers hold their values and that a pointer clear waits until the command ends.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [4:0] A_OPC  = 5'h00;
  localparam logic [4:0] A_CTL  = 5'h02;
  localparam logic [4:0] A_STS  = 5'h03;
  localparam logic [4:0] A_FIFO = 5'h0C;
  localparam logic [4:0] A_PTR  = 5'h0D;
  localparam logic [4:0] A_XIDX = 5'h1E;
  localparam logic [4:0] A_XDAT = 5'h1F;

  localparam logic [7:0] X_TXLEN = 8'd5;
  localparam logic [7:0] X_RXLEN = 8'd6;

  localparam int CTL_GO  = 0;
  localparam int CTL_CLR = 4;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_BIT, S_TRAIL} eng_st_t;
endpackage

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf #(
  parameter int DEPTH = 72,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_clr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] eng_raddr,
  output logic [7:0]       eng_rdata,
  input  logic             eng_we,
  input  logic [PTR_W-1:0] eng_waddr,
  input  logic [7:0]       eng_wdata
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [7:0] mem [DEPTH];

  // Storage: the bus port writes at the pointer, the engine at its own address.
  always_ff @(posedge clk) begin
    if (bus_wr && int'(ptr) < DEPTH) mem[ptr] <= bus_wdata;
    if (eng_we && int'(eng_waddr) < DEPTH) mem[eng_waddr] <= eng_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (ptr_clr) ptr <= '0;
    else if (bus_wr || bus_rd) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assign bus_rdata = (int'(ptr) < DEPTH) ? mem[ptr] : 8'h00;
  assign eng_rdata = (int'(eng_raddr) < DEPTH) ? mem[eng_raddr] : 8'h00;

  // R7
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (int'(eng_waddr) < DEPTH));
endmodule

// File: rtl/spi_cmd_eng.sv
module spi_cmd_eng import spi_cmd_pkg::*; #(
  parameter int DEPTH = 72,
  parameter int DIV   = 2,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int BC_W  = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [7:0]       tx_len,
  input  logic [7:0]       rx_len,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic [7:0]       wdata,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

  eng_st_t        st;
  logic [DCW-1:0] dcnt;
  logic           tick, half, ph;
  logic [2:0]     bit_i;
  logic [BC_W-1:0] byte_i, last_b, txq;
  logic [7:0]     sh_tx, sh_rx;
  logic           sclk_q, cs_q;
  logic [15:0]    room, rx_eff;

  // Receive length clamped to the space left after the transmit bytes.
  always_comb begin
    room   = 16'(DEPTH) - {8'h00, tx_len};
    rx_eff = ({8'h00, rx_len} > room) ? room : {8'h00, rx_len};
  end

  assign tick    = (st != S_IDLE) && (dcnt == DCW'(DIV - 1));
  assign busy    = (st != S_IDLE);
  assign done    = tick && (st == S_TRAIL) && half;
  assign rd_addr = PTR_W'(byte_i);
  assign we      = tick && (st == S_BIT) && ph && (bit_i == 3'd7) && (byte_i > txq);
  assign waddr   = PTR_W'(byte_i - 1'b1);
  assign wdata   = sh_rx;
  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign mosi    = sh_tx[7] & ~cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; half <= 1'b0; ph <= 1'b0; bit_i <= '0;
      byte_i <= '0; last_b <= '0; txq <= '0; sh_tx <= '0; sh_rx <= '0;
      sclk_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      if (st == S_IDLE || tick) dcnt <= '0;
      else dcnt <= dcnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_LEAD;
          cs_q   <= 1'b0;
          half   <= 1'b0;
          ph     <= 1'b0;
          bit_i  <= '0;
          byte_i <= '0;
          txq    <= BC_W'(tx_len);
          last_b <= BC_W'({8'h00, tx_len} + rx_eff);
          sh_tx  <= opcode;
        end
        S_LEAD: if (tick) begin
          if (half) st <= S_BIT;
          half <= ~half;
        end
        S_BIT: if (tick) begin
          if (!ph) begin
            sclk_q <= 1'b1;
            ph     <= 1'b1;
            sh_rx  <= {sh_rx[6:0], miso};
          end else begin
            sclk_q <= 1'b0;
            ph     <= 1'b0;
            if (bit_i == 3'd7) begin
              bit_i <= '0;
              if (byte_i == last_b) begin
                st   <= S_TRAIL;
                half <= 1'b0;
              end else begin
                byte_i <= byte_i + 1'b1;
                sh_tx  <= (byte_i < txq) ? rd_data : 8'h00;
              end
            end else begin
              bit_i <= bit_i + 1'b1;
              sh_tx <= {sh_tx[6:0], 1'b0};
            end
          end
        end
        S_TRAIL: if (tick) begin
          if (half) begin
            st   <= S_IDLE;
            cs_q <= 1'b1;
          end
          half <= ~half;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> (st == S_IDLE));
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cs_q);
  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q);
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl import spi_cmd_pkg::*; #(
  parameter int DEPTH  = 72,
  parameter int MAX_TX = 64,
  parameter int DIV    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_req,
  input  logic       reg_we,
  input  logic [4:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int BC_W  = $clog2(DEPTH + 2);

  logic [7:0] opcode_q, txn_q, rxn_q, xidx_q;
  logic       clr_pend, busy, done, start, wr, rd, ptr_clr;
  logic [PTR_W-1:0] buf_ptr, e_raddr, e_waddr;
  logic [7:0] buf_rdata, e_rdata, e_wdata;
  logic       e_we;

  assign wr    = reg_req && reg_we;
  assign rd    = reg_req && !reg_we;
  assign start = wr && (reg_addr == A_CTL) && reg_wdata[CTL_GO] && !busy;
  assign ptr_clr = (wr && (reg_addr == A_CTL) && reg_wdata[CTL_CLR] && !busy)
                 || (done && clr_pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode_q <= '0; txn_q <= '0; rxn_q <= '0; xidx_q <= '0; clr_pend <= 1'b0;
    end else begin
      if (wr && reg_addr == A_XIDX) xidx_q <= reg_wdata;
      if (wr && !busy && reg_addr == A_OPC) opcode_q <= reg_wdata;
      if (wr && !busy && reg_addr == A_XDAT) begin
        if (xidx_q == X_TXLEN)
          txn_q <= (reg_wdata > 8'(MAX_TX)) ? 8'(MAX_TX) : reg_wdata;
        if (xidx_q == X_RXLEN) rxn_q <= reg_wdata;
      end
      if (done) clr_pend <= 1'b0;
      else if (wr && busy && reg_addr == A_CTL && reg_wdata[CTL_CLR]) clr_pend <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_OPC:  reg_rdata = opcode_q;
      A_CTL:  reg_rdata = {7'b0, busy};
      A_STS:  reg_rdata = {busy, 7'b0};
      A_FIFO: reg_rdata = buf_rdata;
      A_PTR:  reg_rdata = {5'b0, buf_ptr[2:0]};
      A_XIDX: reg_rdata = xidx_q;
      A_XDAT: reg_rdata = (xidx_q == X_TXLEN) ? txn_q :
                          (xidx_q == X_RXLEN) ? rxn_q : 8'h00;
      default: reg_rdata = 8'h00;
    endcase
  end

  spi_cmd_buf #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr),
    .bus_wr(wr && !busy && reg_addr == A_FIFO),
    .bus_rd(rd && reg_addr == A_FIFO),
    .bus_wdata(reg_wdata), .bus_rdata(buf_rdata), .ptr(buf_ptr),
    .eng_raddr(e_raddr), .eng_rdata(e_rdata),
    .eng_we(e_we), .eng_waddr(e_waddr), .eng_wdata(e_wdata)
  );

  spi_cmd_eng #(.DEPTH(DEPTH), .DIV(DIV), .PTR_W(PTR_W), .BC_W(BC_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start),
    .opcode(opcode_q), .tx_len(txn_q), .rx_len(rxn_q),
    .rd_addr(e_raddr), .rd_data(e_rdata),
    .we(e_we), .waddr(e_waddr), .wdata(e_wdata),
    .busy(busy), .done(done),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  // R8
  opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(opcode_q));
  // R2
  tx_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_q <= 8'(MAX_TX));
  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_addr == A_CTL && reg_wdata[CTL_CLR] && !busy) |=> (buf_ptr == '0));
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: tb/spi_cmd_ctrl_tb.sv
module spi_cmd_ctrl_tb;
  localparam int DEPTH = 72;
  localparam int DIV   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0, fails = 0;
  logic [7:0] txd [128];
  logic [7:0] resp [128];
  logic [7:0] cap [128];
  int rises = 0, bc = 0;
  time t_csf, t_first, t_lastf, t_csr;

  always #5 clk = ~clk;

  spi_cmd_ctrl #(.DEPTH(DEPTH), .MAX_TX(64), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // Flash model: drives byte k of resp on transfer byte k, changes on falling edges.
  assign spi_miso = resp[(bc >> 3) & 127][7 - (bc & 7)];
  always @(negedge spi_cs_n) begin t_csf = $time; bc = 0; end
  always @(posedge spi_cs_n) t_csr = $time;
  always @(posedge spi_sclk) begin
    if (rises == 0) t_first = $time;
    cap[(rises >> 3) & 127] = {cap[(rises >> 3) & 127][6:0], spi_mosi};
    rises++;
  end
  always @(negedge spi_sclk) begin t_lastf = $time; bc++; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_req = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_req = 0;
  endtask

  function automatic int rx_eff(input int tx, input int rx);
    return (rx > DEPTH - tx) ? DEPTH - tx : rx;
  endfunction

  task automatic xfer(input logic [7:0] op, input int tx, input int rx, input bit poke);
    logic [7:0] d;
    int n, guard;
    bit last_busy;
    n = rx_eff(tx, rx);
    for (int k = 0; k < 128; k++) resp[k] = 8'($urandom);
    wr(5'h1E, 8'd5); wr(5'h1F, 8'(tx));
    wr(5'h1E, 8'd6); wr(5'h1F, 8'(rx));
    wr(5'h00, op);
    wr(5'h02, 8'h10);
    for (int k = 0; k < tx; k++) begin txd[k] = 8'($urandom); wr(5'h0C, txd[k]); end
    rises = 0;
    wr(5'h02, 8'h01);
    if (poke) begin
      rd(5'h02, d); chk(d[0] == 1'b1, "R4 go bit while busy", d, 1);
      rd(5'h0D, d); chk(d[2:0] == 3'(tx), "R8 ptr during busy", d, tx & 7);
      wr(5'h00, 8'h5A); wr(5'h1F, 8'd9); wr(5'h0C, 8'hEE); wr(5'h02, 8'h10);
      rd(5'h0D, d); chk(d[2:0] == 3'(tx), "R8 deferred clear / ignored fifo write", d, tx & 7);
    end
    @(negedge clk); reg_addr = 5'h03; reg_req = 0;
    last_busy = 1'b0; guard = 0;
    while (spi_cs_n == 1'b0 && guard < 20000) begin
      last_busy = reg_rdata[7];
      @(negedge clk); guard++;
    end
    chk(last_busy == 1'b1, "R4 busy bit while cs low", last_busy, 1);
    chk(reg_rdata[7] == 1'b0, "R9 busy clear with cs release", reg_rdata[7], 0);
    chk(rises == 8 * (1 + tx + n), "R9 clock count", rises, 8 * (1 + tx + n));
    chk(t_first - t_csf == 3 * DIV * 10, "R5 lead time", int'(t_first - t_csf), 3 * DIV * 10);
    chk(t_csr - t_lastf == 2 * DIV * 10, "R5 trail time", int'(t_csr - t_lastf), 2 * DIV * 10);
    chk(cap[0] == op, "R1 opcode first", cap[0], op);
    for (int k = 0; k < tx; k++)
      chk(cap[k + 1] == txd[k], "R1 tx byte order", cap[k + 1], txd[k]);
    if (poke) begin
      rd(5'h0D, d); chk(d[2:0] == 3'd0, "R8 clear applied at end", d, 0);
      rd(5'h00, d); chk(d == op, "R8 opcode write ignored", d, op);
      rd(5'h1F, d); chk(d == 8'(rx), "R8 count write ignored", d, rx);
    end
    wr(5'h02, 8'h10);
    for (int k = 0; k < tx + n; k++) begin
      rd(5'h0C, d);
      if (k < tx) chk(d == txd[k], "R6 echoed tx byte", d, txd[k]);
      else chk(d == resp[k + 1], "R6/R7 received byte", d, resp[k + 1]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5'h00, d); chk(d == 8'h00, "R1 reset opcode", d, 0);
    rd(5'h03, d); chk(d == 8'h00, "R4 reset status", d, 0);
    rd(5'h0D, d); chk(d == 8'h00, "R3 reset pointer", d, 0);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R5 idle pins", {spi_cs_n, spi_sclk}, 2);
    // R2: saturation and unused index
    wr(5'h1E, 8'd5); wr(5'h1F, 8'd100);
    rd(5'h1F, d); chk(d == 8'd64, "R2 tx length saturates", d, 64);
    wr(5'h1E, 8'd3); rd(5'h1F, d); chk(d == 8'h00, "R2 other index", d, 0);
    // R3: pointer advance and clear
    wr(5'h02, 8'h10);
    wr(5'h0C, 8'h11); wr(5'h0C, 8'h22); wr(5'h0C, 8'h33);
    rd(5'h0D, d); chk(d == 8'd3, "R3 pointer advance", d, 3);
    wr(5'h02, 8'h10);
    rd(5'h0C, d); chk(d == 8'h11, "R3 data port read", d, 8'h11);
    rd(5'h0D, d); chk(d == 8'd1, "R3 read advances", d, 1);
    // directed corners
    xfer(8'h9F, 0, 4, 1'b0);   // opcode only, then receive (R1)
    xfer(8'h02, 4, 0, 1'b0);   // write-only (R9)
    xfer(8'h0B, 64, 20, 1'b0); // clamp to 8 received (R7)
    xfer(8'hA5, 3, 2, 1'b1);   // writes during busy (R8)
    for (int i = 0; i < 6; i++)
      xfer(8'($urandom), int'($urandom % 65), int'($urandom % 13), 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule